// File: doc/BRIEF.md
# Vector Coprocessor Control Register File

This block keeps the control state of a 32-element vector coprocessor. It holds a revision word, an 8-bit vector length, a per-element condition mask and two sticky per-element status masks: overflow and saturation. Software reaches these through a move-to/move-from port that selects a register by number. The register numbers are sparse. An access to an unimplemented number is flagged in the same cycle as an illegal-instruction condition.

When a vector instruction issues, the block checks the current length. A length of zero marks the instruction as a no-operation. A length above the element count raises a length-error indication. Otherwise the length is latched as the active length. The functional units return comparison, overflow and saturation results with valid strobes. Only elements below the active length are updated. The comparison mask is replaced element by element. The overflow and saturation masks accumulate by OR, and only a software write can clear them.

Top module: `vctl_regs`

## Requirements
- R1: After reset the length, the active length and the condition, overflow and saturation masks are all zero.
- R2: Register numbers are decoded as follows: 0 is revision, 1 is cycle-count shadow, 2 is length, 4 is condition, 8 is overflow and 12 is saturation. In the same cycle, a read or a write of any other number raises `cr_illegal_o`, returns zero and changes no state.
- R3: Register 0 is read-only and reads as {16'b0, implementation[7:0], revision[7:0]}. Register 1 is read-only and reads `cycle_count_i`. Writes to either number are ignored.
- R4: A write to register 2 stores bits 7..0 of the write data. On a read, bits 31..8 of register 2 are zero. Writing the length never changes the active length of an instruction already issued.
- R5: At issue, `issue_nop_o` is high when the length is 0, and `issue_len_err_o` is high when the length is above 32, both combinationally in the issue cycle. At the next edge the active length becomes the length if it lies in 1..32, and 0 otherwise.
- R6: A comparison strobe replaces condition bit e with result bit e for every element e below the active length. All other bits keep their values.
- R7: An overflow strobe ORs result bit e into overflow bit e for every element below the active length. Overflow bits fall only through a software write to register 8.
- R8: A saturation strobe ORs result bit e into saturation bit e for every element below the active length. Saturation bits fall only through a software write to register 12.
- R9: When a software write and a functional-unit strobe target the same mask in one cycle, the mask takes the written value and the strobe is dropped.
- R10: Reads are combinational and return the value held before the current edge. `cr_rdata_o` is zero when no read is requested. An issue in the same cycle as a length write checks and latches the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cr_rd_i | input | 1 | Control register read request |
| cr_wr_i | input | 1 | Control register write request |
| cr_addr_i | input | 5 | Control register number |
| cr_wdata_i | input | 32 | Write data |
| cr_rdata_o | output | 32 | Read data (zero when no legal read) |
| cr_illegal_o | output | 1 | Access to an unimplemented number |
| cycle_count_i | input | 32 | Cycle counter value shadowed at number 1 |
| issue_i | input | 1 | Vector instruction issue strobe |
| issue_nop_o | output | 1 | Issued with length zero |
| issue_len_err_o | output | 1 | Issued with length above element count |
| cmp_valid_i | input | 1 | Comparison results valid |
| cmp_bits_i | input | 32 | Per-element comparison results |
| ovf_valid_i | input | 1 | Overflow indications valid |
| ovf_bits_i | input | 32 | Per-element overflow indications |
| sat_valid_i | input | 1 | Saturation indications valid |
| sat_bits_i | input | 32 | Per-element saturation indications |

## Verification
Two pairs of events can land in the same cycle. The first pair is a software write to a flag mask and a functional-unit strobe to that mask. The second pair is a length write and an instruction issue. The bench forces both pairs in directed steps. For example, it writes a pattern to the condition mask while a comparison strobe carries zeros. It also writes a new length while issuing, then strobes all-ones results to show which length bounded the update. A random phase then mixes these collisions freely. A behavioural model predicts the read data, the illegal flag and the issue indications each cycle, and the bench compares them against the design.

// File: rtl/vctl_pkg.sv
package vctl_pkg;
  localparam int unsigned CR_AW = 5;

  localparam logic [CR_AW-1:0] CR_REV = 5'd0;
  localparam logic [CR_AW-1:0] CR_CNT = 5'd1;
  localparam logic [CR_AW-1:0] CR_LEN = 5'd2;
  localparam logic [CR_AW-1:0] CR_CMP = 5'd4;
  localparam logic [CR_AW-1:0] CR_OVF = 5'd8;
  localparam logic [CR_AW-1:0] CR_SAT = 5'd12;

  typedef struct packed {
    logic rev;
    logic cnt;
    logic len;
    logic cmp;
    logic ovf;
    logic sat;
  } cr_sel_t;
endpackage

// File: rtl/vctl_decode.sv
module vctl_decode
  import vctl_pkg::*;
(
  input  logic [CR_AW-1:0] addr_i,
  input  logic             rd_i,
  input  logic             wr_i,
  output cr_sel_t          sel_o,
  output logic             illegal_o
);
  cr_sel_t sel;

  always_comb begin
    sel     = '0;
    sel.rev = (addr_i == CR_REV);
    sel.cnt = (addr_i == CR_CNT);
    sel.len = (addr_i == CR_LEN);
    sel.cmp = (addr_i == CR_CMP);
    sel.ovf = (addr_i == CR_OVF);
    sel.sat = (addr_i == CR_SAT);
  end

  assign sel_o     = sel;
  assign illegal_o = (rd_i | wr_i) & ~(|sel);

  // R2
  sel_onehot_chk: assert final ($onehot0(sel));
endmodule

// File: rtl/vctl_len_unit.sv
module vctl_len_unit #(
  parameter int unsigned LEN_W    = 8,
  parameter int unsigned NUM_ELEM = 32,
  localparam int unsigned ACT_W   = $clog2(NUM_ELEM + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [LEN_W-1:0]    wdata_i,
  input  logic                issue_i,
  output logic [LEN_W-1:0]    len_o,
  output logic                nop_o,
  output logic                err_o,
  output logic [NUM_ELEM-1:0] mask_o
);
  logic [LEN_W-1:0] len_q;
  logic [ACT_W-1:0] act_q;
  logic             len_zero, len_big;

  assign len_zero = (len_q == '0);
  assign len_big  = (len_q > LEN_W'(NUM_ELEM));
  assign nop_o    = issue_i & len_zero;
  assign err_o    = issue_i & len_big;
  assign len_o    = len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
    end else if (we_i) begin
      len_q <= wdata_i;
    end
  end

  // active length: issue samples the pre-write length
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (issue_i) begin
      act_q <= (len_zero | len_big) ? '0 : len_q[ACT_W-1:0];
    end
  end

  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_mask
    assign mask_o[e] = (act_q > ACT_W'(e));
  end

  // R4
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(len_q));
  // R4
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(act_q));
  // R5
  act_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> (act_q <= ACT_W'(NUM_ELEM)));
  // R5
  issue_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nop_o && err_o));
endmodule

// File: rtl/vctl_flag_reg.sv
module vctl_flag_reg #(
  parameter int unsigned N      = 32,
  parameter bit          STICKY = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_we_i,
  input  logic [N-1:0] sw_data_i,
  input  logic         upd_valid_i,
  input  logic [N-1:0] upd_bits_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q, upd_val;

  if (STICKY) begin : g_sticky
    assign upd_val = q_q | (upd_bits_i & mask_i);
  end else begin : g_replace
    assign upd_val = (q_q & ~mask_i) | (upd_bits_i & mask_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else if (sw_we_i) begin
      q_q <= sw_data_i;
    end else if (upd_valid_i) begin
      q_q <= upd_val;
    end
  end

  assign q_o = q_q;

  // R6
  outside_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_we_i |=> (((q_q ^ $past(q_q)) & ~$past(mask_i)) == '0));
  // R9
  sw_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> (q_q == $past(sw_data_i)));

  if (STICKY) begin : g_sticky_chk
    // R7
    no_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sw_we_i |=> ((~q_q & $past(q_q)) == '0));
  end
endmodule

// File: rtl/vctl_regs.sv
module vctl_regs
  import vctl_pkg::*;
#(
  parameter int unsigned NUM_ELEM = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LEN_W    = 8,
  parameter logic [7:0]  IMP_ID   = 8'h00,
  parameter logic [7:0]  REV_ID   = 8'h01
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cr_rd_i,
  input  logic                cr_wr_i,
  input  logic [CR_AW-1:0]    cr_addr_i,
  input  logic [DATA_W-1:0]   cr_wdata_i,
  output logic [DATA_W-1:0]   cr_rdata_o,
  output logic                cr_illegal_o,
  input  logic [DATA_W-1:0]   cycle_count_i,
  input  logic                issue_i,
  output logic                issue_nop_o,
  output logic                issue_len_err_o,
  input  logic                cmp_valid_i,
  input  logic [NUM_ELEM-1:0] cmp_bits_i,
  input  logic                ovf_valid_i,
  input  logic [NUM_ELEM-1:0] ovf_bits_i,
  input  logic                sat_valid_i,
  input  logic [NUM_ELEM-1:0] sat_bits_i
);
  localparam logic [DATA_W-1:0] REV_WORD = DATA_W'({IMP_ID, REV_ID});

  cr_sel_t             sel;
  logic [LEN_W-1:0]    len;
  logic [NUM_ELEM-1:0] mask, cmp_q, ovf_q, sat_q;

  vctl_decode u_decode (
    .addr_i    (cr_addr_i),
    .rd_i      (cr_rd_i),
    .wr_i      (cr_wr_i),
    .sel_o     (sel),
    .illegal_o (cr_illegal_o)
  );

  vctl_len_unit #(.LEN_W(LEN_W), .NUM_ELEM(NUM_ELEM)) u_len (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cr_wr_i & sel.len),
    .wdata_i (cr_wdata_i[LEN_W-1:0]),
    .issue_i (issue_i),
    .len_o   (len),
    .nop_o   (issue_nop_o),
    .err_o   (issue_len_err_o),
    .mask_o  (mask)
  );

  vctl_flag_reg #(.N(NUM_ELEM), .STICKY(1'b0)) u_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_we_i     (cr_wr_i & sel.cmp),
    .sw_data_i   (cr_wdata_i[NUM_ELEM-1:0]),
    .upd_valid_i (cmp_valid_i),
    .upd_bits_i  (cmp_bits_i),
    .mask_i      (mask),
    .q_o         (cmp_q)
  );

  vctl_flag_reg #(.N(NUM_ELEM), .STICKY(1'b1)) u_ovf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_we_i     (cr_wr_i & sel.ovf),
    .sw_data_i   (cr_wdata_i[NUM_ELEM-1:0]),
    .upd_valid_i (ovf_valid_i),
    .upd_bits_i  (ovf_bits_i),
    .mask_i      (mask),
    .q_o         (ovf_q)
  );

  vctl_flag_reg #(.N(NUM_ELEM), .STICKY(1'b1)) u_sat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sw_we_i     (cr_wr_i & sel.sat),
    .sw_data_i   (cr_wdata_i[NUM_ELEM-1:0]),
    .upd_valid_i (sat_valid_i),
    .upd_bits_i  (sat_bits_i),
    .mask_i      (mask),
    .q_o         (sat_q)
  );

  always_comb begin
    cr_rdata_o = '0;
    if (cr_rd_i) begin
      if (sel.rev) cr_rdata_o = REV_WORD;
      if (sel.cnt) cr_rdata_o = cycle_count_i;
      if (sel.len) cr_rdata_o = DATA_W'(len);
      if (sel.cmp) cr_rdata_o = DATA_W'(cmp_q);
      if (sel.ovf) cr_rdata_o = DATA_W'(ovf_q);
      if (sel.sat) cr_rdata_o = DATA_W'(sat_q);
    end
  end

  // R2
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_illegal_o |-> (cr_rdata_o == '0));
  // R3
  rev_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_rd_i && cr_addr_i == CR_REV) |-> (cr_rdata_o[DATA_W-1:16] == '0));
  // R10
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cr_rd_i |-> (cr_rdata_o == '0));
endmodule

// File: tb/vctl_regs_bench.sv
module vctl_regs_bench;
  localparam int CLK_P = 10;
  localparam logic [7:0] IMP = 8'h00;
  localparam logic [7:0] REV = 8'h01;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rd = 0, wr = 0, issue = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, cyc = '0;
  logic        cmp_v = 0, ovf_v = 0, sat_v = 0;
  logic [31:0] cmp_b = '0, ovf_b = '0, sat_b = '0;
  logic [31:0] rdata;
  logic        illegal, nop, lerr;

  int n_cmp = 0, n_bad = 0;

  // reference state
  logic [7:0]  m_len;
  int          m_act;
  logic [31:0] m_cond, m_ovf, m_sat;

  always #(CLK_P/2) clk = ~clk;

  vctl_regs u_vctl_regs (
    .clk_i(clk), .rst_ni(rst_n),
    .cr_rd_i(rd), .cr_wr_i(wr), .cr_addr_i(addr), .cr_wdata_i(wdata),
    .cr_rdata_o(rdata), .cr_illegal_o(illegal), .cycle_count_i(cyc),
    .issue_i(issue), .issue_nop_o(nop), .issue_len_err_o(lerr),
    .cmp_valid_i(cmp_v), .cmp_bits_i(cmp_b),
    .ovf_valid_i(ovf_v), .ovf_bits_i(ovf_b),
    .sat_valid_i(sat_v), .sat_bits_i(sat_b)
  );

  function automatic bit legal(input logic [4:0] a);
    return a == 0 || a == 1 || a == 2 || a == 4 || a == 8 || a == 12;
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (!rd) return '0;
    case (addr)
      5'd0:    return {16'h0, IMP, REV};
      5'd1:    return cyc;
      5'd2:    return {24'h0, m_len};
      5'd4:    return m_cond;
      5'd8:    return m_ovf;
      5'd12:   return m_sat;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_update();
    logic [31:0] msk = '0;
    for (int e = 0; e < 32; e++) if (e < m_act) msk[e] = 1'b1;
    if (wr && addr == 5'd4) m_cond = wdata;
    else if (cmp_v) m_cond = (m_cond & ~msk) | (cmp_b & msk);
    if (wr && addr == 5'd8) m_ovf = wdata;
    else if (ovf_v) m_ovf = m_ovf | (ovf_b & msk);
    if (wr && addr == 5'd12) m_sat = wdata;
    else if (sat_v) m_sat = m_sat | (sat_b & msk);
    if (issue) m_act = (m_len == 0 || m_len > 32) ? 0 : int'(m_len);
    if (wr && addr == 5'd2) m_len = wdata[7:0];
  endtask

  // compare all outputs, advance one clock, return at negedge
  task automatic step(input string tag);
    #(CLK_P/4);
    check(tag, "rdata",   rdata, exp_rdata());
    check(tag, "illegal", {31'h0, illegal}, {31'h0, (rd || wr) && !legal(addr)});
    check(tag, "nop",     {31'h0, nop},  {31'h0, issue && m_len == 0});
    check(tag, "len_err", {31'h0, lerr}, {31'h0, issue && m_len > 32});
    @(posedge clk);
    model_update();
    cyc = cyc + 32'd1;
    @(negedge clk);
  endtask

  task automatic idle();
    rd = 0; wr = 0; issue = 0; cmp_v = 0; ovf_v = 0; sat_v = 0;
    addr = '0; wdata = '0; cmp_b = '0; ovf_b = '0; sat_b = '0;
  endtask

  task automatic rd_reg(input logic [4:0] a, input string tag);
    idle(); rd = 1; addr = a; step(tag);
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d, input string tag);
    idle(); wr = 1; addr = a; wdata = d; step(tag);
  endtask

  task automatic do_issue(input string tag);
    idle(); issue = 1; step(tag);
  endtask

  task automatic read_flags(input string tag);
    rd_reg(5'd4, tag); rd_reg(5'd8, tag); rd_reg(5'd12, tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_len = '0; m_act = 0; m_cond = '0; m_ovf = '0; m_sat = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    rd_reg(5'd2, "R1"); read_flags("R1");
    do_issue("R1");
    idle(); cmp_v = 1; cmp_b = '1; ovf_v = 1; ovf_b = '1; step("R1");
    read_flags("R1");

    // R3: read-only words
    rd_reg(5'd0, "R3");
    wr_reg(5'd0, 32'hFFFF_FFFF, "R3");
    rd_reg(5'd0, "R3");
    wr_reg(5'd1, 32'h1234_5678, "R3");
    rd_reg(5'd1, "R3");

    // R2: full number sweep, illegal write leaves state alone
    for (int a = 0; a < 32; a++) rd_reg(5'(a), "R2");
    for (int a = 0; a < 32; a++) if (!legal(5'(a))) wr_reg(5'(a), 32'hDEAD_BEEF, "R2");
    rd_reg(5'd2, "R2"); read_flags("R2");

    // R4: length width
    wr_reg(5'd2, 32'hFFFF_FF05, "R4");
    rd_reg(5'd2, "R4");

    // R5 / R6: issue with length 5, compare under mask
    do_issue("R5");
    idle(); cmp_v = 1; cmp_b = 32'hFFFF_FFFF; step("R6");
    rd_reg(5'd4, "R6");
    idle(); cmp_v = 1; cmp_b = 32'h0000_0002; step("R6");
    rd_reg(5'd4, "R6");

    // R10: issue and length write together; old length 5 is checked and latched
    wr_reg(5'd4, 32'h0, "R10");
    idle(); wr = 1; addr = 5'd2; wdata = 32'd20; issue = 1; step("R10");
    idle(); cmp_v = 1; cmp_b = '1; step("R10");
    rd_reg(5'd4, "R10");
    // R4: length write alone leaves active length
    wr_reg(5'd2, 32'd3, "R4");
    wr_reg(5'd4, 32'h0, "R4");
    idle(); cmp_v = 1; cmp_b = '1; step("R4");
    rd_reg(5'd4, "R4");
    wr_reg(5'd2, 32'd20, "R4");
    do_issue("R5");

    // R7: overflow sticky
    idle(); ovf_v = 1; ovf_b = 32'h0000_0003; step("R7");
    idle(); ovf_v = 1; ovf_b = 32'h0000_0004; step("R7");
    idle(); ovf_v = 1; ovf_b = 32'h0000_0000; step("R7");
    idle(); ovf_v = 1; ovf_b = 32'hFFF0_0000; step("R7");
    rd_reg(5'd8, "R7");
    wr_reg(5'd8, 32'h0, "R7");
    rd_reg(5'd8, "R7");

    // R8: saturation sticky
    idle(); sat_v = 1; sat_b = 32'h0008_0001; step("R8");
    idle(); sat_v = 1; sat_b = 32'h0000_0010; step("R8");
    rd_reg(5'd12, "R8");
    wr_reg(5'd12, 32'h0000_0001, "R8");
    rd_reg(5'd12, "R8");

    // R9: software write beats functional-unit strobe
    idle(); wr = 1; addr = 5'd4; wdata = 32'hA5A5_A5A5; cmp_v = 1; cmp_b = '0; step("R9");
    idle(); wr = 1; addr = 5'd8; wdata = 32'h0; ovf_v = 1; ovf_b = '1; step("R9");
    idle(); wr = 1; addr = 5'd12; wdata = 32'h8000_0000; sat_v = 1; sat_b = '1; step("R9");
    read_flags("R9");

    // R5: length bounds
    wr_reg(5'd2, 32'd33, "R5");
    do_issue("R5");
    idle(); ovf_v = 1; ovf_b = '1; step("R5");
    rd_reg(5'd8, "R5");
    wr_reg(5'd2, 32'd32, "R5");
    do_issue("R5");
    idle(); ovf_v = 1; ovf_b = '1; step("R5");
    rd_reg(5'd8, "R5");
    wr_reg(5'd2, 32'd200, "R5");
    do_issue("R5");
    wr_reg(5'd2, 32'd0, "R5");
    do_issue("R5");

    // R9 / R10: random mix of collisions
    for (int i = 0; i < 600; i++) begin
      idle();
      rd    = ($urandom % 2) == 0;
      wr    = ($urandom % 3) == 0;
      addr  = ($urandom % 4 == 0) ? 5'($urandom) : 5'($urandom % 13);
      wdata = ($urandom % 2 == 0) ? 32'($urandom % 40) : $urandom;
      issue = ($urandom % 4) == 0;
      cmp_v = ($urandom % 3) == 0; cmp_b = $urandom;
      ovf_v = ($urandom % 5) == 0; ovf_b = $urandom;
      sat_v = ($urandom % 5) == 0; sat_b = $urandom;
      step("R9");
    end
    read_flags("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule